// File: doc/BRIEF.md
# ROM Read Wait-State Generator

This block stretches bus read cycles that target the on-board ROM by a selectable number of clock periods. Address decode elsewhere supplies a per-cycle qualifier saying the current cycle is a ROM read. When such a cycle starts and the ROM is switched in, the block holds the shared bus ready line low for the selected number of clocks and then releases it. The bus master adds one wait state for each clock that ready is held low.

The wait count comes from a 4-bit switch value. Settings above the supported maximum (eight by default) are clamped to that maximum. RAM cycles, and ROM cycles made while the ROM is switched out, pass with no extra clocks. A separate enable stands in for the jumper that links the block to the ready line. With that enable clear, the block never pulls ready and never reports waiting. The ready output is open-drain: the block only sinks the line while waiting and otherwise leaves it released. A wait-active flag mirrors the stretch, for an indicator lamp.

Top module: `rom_wait_gen`

## Requirements
- R1: A qualifying start (cyc_start=1, rom_rd_hit=1, rom_en=1, rdy_drv_en=1, sampled at a rising edge while idle) with wait_sel=N, 1<=N<=8, sets rdy_sink and wait_busy to 1 from that edge for exactly N clock periods, after which both return to 0.
- R2: A qualifying start with wait_sel=0 leaves rdy_sink and wait_busy at 0, so the cycle completes with no extra clocks.
- R3: Any wait_sel value from 9 to 15 yields exactly 8 wait clocks (clamped to MAX_WAITS).
- R4: A cycle start with rom_rd_hit=0 (a RAM access or a write) produces no wait: rdy_sink and wait_busy stay 0.
- R5: A cycle start with rom_en=0 produces no wait, whatever wait_sel is.
- R6: With rdy_drv_en=0 the block never sinks the ready line and never sets wait_busy.
- R7: A cycle start seen while a wait is still counting is ignored: the running wait keeps its original length and no second wait follows.
- R8: Synchronous active-high rst clears any wait in progress; rdy_sink and wait_busy are 0 in the clock after rst is seen.
- R9: rdy_sink is 1 only while wait_busy is 1; at all other times the ready line is released (rdy_sink=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| rom_rd_hit | input | 1 | Current cycle is a read decoded to the ROM |
| rom_en | input | 1 | ROM is currently switched into the address space |
| wait_sel | input | 4 | Switch-set wait count, 0 to 15 (values above MAX_WAITS clamp) |
| rdy_drv_en | input | 1 | Allows the block to drive the ready line |
| rdy_sink | output | 1 | 1 = pull bus ready low (not ready); 0 = line released |
| wait_busy | output | 1 | Wait states are being inserted |

## Verification
The bench builds the block with its defaults, a 4-bit count and an eight-clock ceiling. With these, every legal setting from zero to eight can be swept and the length of each stretch measured. The seven out-of-range codes above eight are also reachable, so the clamp is tested on all of them. The longest stretch is eight clocks, which leaves room for a second start strobe and a reset to land inside a running wait.

// File: rtl/rws_pkg.sv
package rws_pkg;
  localparam int unsigned DEF_CNT_W     = 4;
  localparam int unsigned DEF_MAX_WAITS = 8;
endpackage

// File: rtl/rws_qualify.sv
module rws_qualify #(
  parameter int unsigned CNT_W     = rws_pkg::DEF_CNT_W,
  parameter int unsigned MAX_WAITS = rws_pkg::DEF_MAX_WAITS
) (
  input  logic             cyc_start,
  input  logic             rom_rd_hit,
  input  logic             rom_en,
  input  logic             rdy_drv_en,
  input  logic [CNT_W-1:0] wait_sel,
  output logic             go,
  output logic [CNT_W-1:0] load_val
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_WAITS);

  logic [CNT_W-1:0] eff;

  // clamp only when the switch field can exceed the ceiling
  generate
    if (MAX_WAITS < (2 ** CNT_W) - 1) begin : g_clamp
      assign eff = (wait_sel > MAX_V) ? MAX_V : wait_sel;
    end else begin : g_pass
      assign eff = wait_sel;
    end
  endgenerate

  assign load_val = eff;
  assign go = cyc_start & rom_rd_hit & rom_en & rdy_drv_en & (eff != '0);
endmodule

// File: rtl/rws_counter.sv
module rws_counter #(
  parameter int unsigned CNT_W = rws_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      busy   <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        busy   <= 1'b1;
        remain <= load_val - 1'b1;
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/rom_wait_gen.sv
module rom_wait_gen #(
  parameter int unsigned CNT_W     = rws_pkg::DEF_CNT_W,
  parameter int unsigned MAX_WAITS = rws_pkg::DEF_MAX_WAITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic             rom_rd_hit,
  input  logic             rom_en,
  input  logic [CNT_W-1:0] wait_sel,
  input  logic             rdy_drv_en,
  output logic             rdy_sink,
  output logic             wait_busy
);
  logic             go;
  logic [CNT_W-1:0] load_val;
  logic             busy;

  rws_qualify #(.CNT_W(CNT_W), .MAX_WAITS(MAX_WAITS)) u_qual (
    .cyc_start (cyc_start),
    .rom_rd_hit(rom_rd_hit),
    .rom_en    (rom_en),
    .rdy_drv_en(rdy_drv_en),
    .wait_sel  (wait_sel),
    .go        (go),
    .load_val  (load_val)
  );

  rws_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .load_val(load_val),
    .busy    (busy)
  );

  assign rdy_sink  = busy;
  assign wait_busy = busy;
endmodule

// File: rtl/rom_wait_gen_chk.sv
module rom_wait_gen_chk #(
  parameter int unsigned CNT_W     = rws_pkg::DEF_CNT_W,
  parameter int unsigned MAX_WAITS = rws_pkg::DEF_MAX_WAITS
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_start,
  input logic             rom_rd_hit,
  input logic             rom_en,
  input logic [CNT_W-1:0] wait_sel,
  input logic             rdy_drv_en,
  input logic             rdy_sink,
  input logic             wait_busy
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_WAITS);

  logic             qual;
  logic [CNT_W-1:0] exp_len;
  logic [CNT_W:0]   run_len;

  assign qual = !wait_busy && cyc_start && rom_rd_hit && rom_en && rdy_drv_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_len <= '0;
      run_len <= '0;
    end else if (qual && wait_sel != '0) begin
      exp_len <= (wait_sel > MAX_V) ? MAX_V : wait_sel;
      run_len <= '0;
    end else if (wait_busy) begin
      run_len <= run_len + 1'b1;
    end
  end

  a_r1_starts: assert property (@(posedge clk) disable iff (rst)
    (qual && wait_sel != '0) |=> wait_busy);
  a_r1_r3_r7_length: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_busy) |-> (run_len == {1'b0, exp_len}));
  a_r2_zero: assert property (@(posedge clk) disable iff (rst)
    (qual && wait_sel == '0) |=> !wait_busy);
  a_r4_ram: assert property (@(posedge clk) disable iff (rst)
    (!wait_busy && !rom_rd_hit) |=> !wait_busy);
  a_r5_rom_off: assert property (@(posedge clk) disable iff (rst)
    (!wait_busy && !rom_en) |=> !wait_busy);
  a_r6_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!wait_busy && !rdy_drv_en) |=> !rdy_sink);
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!wait_busy && !rdy_sink));
  a_r9_sink: assert property (@(posedge clk) disable iff (rst)
    rdy_sink |-> wait_busy);
endmodule

bind rom_wait_gen rom_wait_gen_chk #(.CNT_W(CNT_W), .MAX_WAITS(MAX_WAITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_start (cyc_start),
  .rom_rd_hit(rom_rd_hit),
  .rom_en    (rom_en),
  .wait_sel  (wait_sel),
  .rdy_drv_en(rdy_drv_en),
  .rdy_sink  (rdy_sink),
  .wait_busy (wait_busy)
);

// File: tb/rom_wait_gen_bench.sv
module rom_wait_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_start = 1'b0;
  logic       rom_rd_hit = 1'b0;
  logic       rom_en = 1'b0;
  logic [3:0] wait_sel = 4'd0;
  logic       rdy_drv_en = 1'b0;
  logic       rdy_sink;
  logic       wait_busy;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rom_wait_gen u_rom_wait_gen (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .rom_rd_hit(rom_rd_hit),
    .rom_en(rom_en), .wait_sel(wait_sel), .rdy_drv_en(rdy_drv_en),
    .rdy_sink(rdy_sink), .wait_busy(wait_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle start, then count clocks with wait_busy high
  task automatic run_wait(input string req, input logic [3:0] sel, input logic hit,
                          input logic ren, input logic drv, input int exp);
    int cnt = 0;
    int sink_bad = 0;
    @(negedge clk);
    wait_sel = sel; rom_rd_hit = hit; rom_en = ren; rdy_drv_en = drv; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    while (wait_busy && cnt < 40) begin
      if (rdy_sink !== 1'b1) sink_bad++;
      cnt++;
      @(negedge clk);
    end
    check(req, cnt, exp);
    check({req, " sink"}, sink_bad, 0);
    check({req, " released"}, int'(rdy_sink), 0);
  endtask

  task automatic t_reset_state();
    check("R8 reset busy", int'(wait_busy), 0);
    check("R9 reset sink", int'(rdy_sink), 0);
  endtask

  task automatic t_sweep();
    run_wait("R2 zero", 4'd0, 1'b1, 1'b1, 1'b1, 0);
    for (int n = 1; n <= 8; n++)
      run_wait("R1 length", 4'(n), 1'b1, 1'b1, 1'b1, n);
  endtask

  task automatic t_clamp();
    for (int n = 9; n <= 15; n++)
      run_wait("R3 clamp", 4'(n), 1'b1, 1'b1, 1'b1, 8);
  endtask

  task automatic t_blocked();
    run_wait("R4 ram", 4'd5, 1'b0, 1'b1, 1'b1, 0);
    run_wait("R5 rom off", 4'd5, 1'b1, 1'b0, 1'b1, 0);
    run_wait("R6 no drive", 4'd5, 1'b1, 1'b1, 1'b0, 0);
    run_wait("R6 no drive max", 4'd8, 1'b1, 1'b1, 1'b0, 0);
  endtask

  task automatic t_ignore();
    int cnt = 0;
    @(negedge clk);
    wait_sel = 4'd3; rom_rd_hit = 1'b1; rom_en = 1'b1; rdy_drv_en = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    while (wait_busy && cnt < 40) begin
      cnt++;
      if (cnt == 2) begin wait_sel = 4'd8; cyc_start = 1'b1; end
      else cyc_start = 1'b0;
      @(negedge clk);
    end
    cyc_start = 1'b0;
    check("R7 ignore length", cnt, 3);
    repeat (3) @(negedge clk);
    check("R7 no second wait", int'(wait_busy), 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    wait_sel = 4'd6; rom_rd_hit = 1'b1; rom_en = 1'b1; rdy_drv_en = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    check("R1 busy before reset", int'(wait_busy), 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 busy cleared", int'(wait_busy), 0);
    check("R8 sink cleared", int'(rdy_sink), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 stays idle", int'(wait_busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_sweep();
    t_clamp();
    t_blocked();
    t_ignore();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule